// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block carries out the built-in self-test of a small character display controller. A host writes an 8-bit control word. When that write sets the start bit while the block is idle, the block raises `busy` and runs a test of fixed length. During the first half of the test the block steps through every address of an internal character-decoder ROM and adds up the ROM words into a 16-bit checksum. Across the whole test it drives a checkerboard onto the LED column bus while the row index scans. The checkerboard is shown during the first half and its inverse during the second half.

In the last cycles of the test the block issues write strobes that re-initialise the display memories. Every character location is loaded with the space code. Every flash location is cleared. The user-character address register is set to all ones. When `busy` drops, the control word reads back as zero except for the result bit. That bit is 1 when the checksum matched the expected constant and 0 when it did not. An input that corrupts one ROM word lets the failing path be exercised.

Top module: `disp_selftest`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ctrl_rdata` is 0, `busy` is 0, `mem_we` is 0, `led_row` is 0 and `led_cols` is 0.
- R2: A write (`host_wr`=1) with `host_wdata` bit 6 set while idle raises `busy` from the next cycle. `busy` then stays high for exactly 2^(PHASE_W+1) cycles.
- R3: A write while idle stores `host_wdata` bits 7, 6 and 4..0 into the control word. Control-word bit 5 is read-only and keeps its value across such a write.
- R4: Writes while `busy` is high are ignored. `ctrl_rdata` holds its value from the first busy cycle until `busy` falls.
- R5: ROM word a is (29*a + 7) mod 256 for a = 0 .. 2^ROM_AW-1. When `rom_fault` is high, bit 0 of word 0 is inverted. The test passes only if the 16-bit modular sum of all words equals `EXP_SUM`.
- R6: In busy cycle t (t = 0 in the first busy cycle), `led_row` equals t mod ROWS. Bit c of `led_cols` equals (t mod ROWS + c) mod 2 in the first half of the test, and the inverse of that value in the second half. While idle, both `led_row` and `led_cols` are 0.
- R7: In the last 2*CHAR_N+1 busy cycles, `mem_we` is 1 and the block issues the following writes in order:
  - character writes (`mem_sel`=0) to addresses 0..CHAR_N-1 with data 20h;
  - flash writes (`mem_sel`=1) to addresses 0..CHAR_N-1 with data 00h;
  - one user-character address write (`mem_sel`=2) with data FFh.
- R8: In the first idle cycle after a test, `ctrl_rdata` equals 20h after a pass and 00h after a fail.
- R9: `mem_we` is 0 in every cycle outside the final write window of R7, including all idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Control-word write strobe |
| host_wdata | input | 8 | Control-word write data |
| rom_fault | input | 1 | Inverts bit 0 of ROM word 0 |
| ctrl_rdata | output | 8 | Control word read-back |
| busy | output | 1 | High while the test runs |
| led_row | output | $clog2(ROWS) | Scanned row index |
| led_cols | output | COLS | LED column drive pattern |
| mem_we | output | 1 | Re-initialisation write strobe |
| mem_sel | output | 2 | Write target: 0 character, 1 flash, 2 user-character address |
| mem_addr | output | $clog2(CHAR_N) | Write address |
| mem_wdata | output | 8 | Write data |

## Verification
The bench runs three tests with different stimulus:
- a clean ROM, which must pass;
- `rom_fault` high, which must fail, so a wrong sum cannot be mistaken for a correct one;
- a second clean run after the failure, which shows that a stale result bit does not leak into the next test.

Idle writes with bit 5 set and with bit 5 clear separate correct read-only handling from a plain register store. Writes issued in the middle of a run, including ones that carry a start bit, show whether writes are locked out while busy. A cycle-by-cycle model compares the row scan, the column polarity, and the exact order, addresses and data of the final writes. Any one-cycle error in the phase boundary or in the write window is therefore caught.

// File: rtl/st_pkg.sv
package st_pkg;

    typedef enum logic [1:0] {
        SEL_CHAR  = 2'd0,
        SEL_FLASH = 2'd1,
        SEL_UDC   = 2'd2
    } mem_sel_e;

    localparam logic [7:0] SPACE_CODE = 8'h20;

    function automatic logic [7:0] rom_word(input int unsigned a);
        return 8'((a * 29 + 7) % 256);
    endfunction

    function automatic logic [15:0] rom_sum(input int unsigned n);
        logic [15:0] s;
        s = '0;
        for (int unsigned i = 0; i < n; i++) begin
            s = s + 16'(rom_word(i));
        end
        return s;
    endfunction

endpackage

// File: rtl/st_rom.sv
module st_rom
    import st_pkg::*;
#(
    parameter int unsigned ROM_AW = 7
) (
    input  logic [ROM_AW-1:0] addr,
    input  logic              fault,
    output logic [7:0]        data
);
    logic hit_zero;

    assign hit_zero = fault && (addr == '0);
    assign data     = rom_word(32'(addr)) ^ {7'b0, hit_zero};
endmodule

// File: rtl/st_pattern.sv
module st_pattern #(
    parameter int unsigned ROW_W = 3,
    parameter int unsigned COLS  = 5
) (
    input  logic             en,
    input  logic             invert,
    input  logic [ROW_W-1:0] row,
    output logic [COLS-1:0]  cols
);
    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam logic ODD = (c % 2) == 1;
        assign cols[c] = en & (row[0] ^ ODD ^ invert);
    end
endmodule

// File: rtl/st_init_seq.sv
module st_init_seq
    import st_pkg::*;
#(
    parameter int unsigned CNT_W  = 18,
    parameter int unsigned CHAR_N = 8,
    parameter int unsigned AW     = 3
) (
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    output logic             we,
    output logic [1:0]       sel,
    output logic [AW-1:0]    addr,
    output logic [7:0]       wdata
);
    localparam int unsigned TOTAL  = 1 << CNT_W;
    localparam int unsigned INIT_N = 2 * CHAR_N + 1;
    localparam int unsigned START  = TOTAL - INIT_N;

    logic [CNT_W-1:0] k;

    always_comb begin
        k     = cnt - CNT_W'(START);
        we    = 1'b0;
        sel   = SEL_CHAR;
        addr  = '0;
        wdata = '0;
        if (en && (cnt >= CNT_W'(START))) begin
            we = 1'b1;
            if (k < CNT_W'(CHAR_N)) begin
                sel   = SEL_CHAR;
                addr  = AW'(k);
                wdata = SPACE_CODE;
            end else if (k < CNT_W'(2 * CHAR_N)) begin
                sel   = SEL_FLASH;
                addr  = AW'(k - CNT_W'(CHAR_N));
                wdata = 8'h00;
            end else begin
                sel   = SEL_UDC;
                wdata = 8'hFF;
            end
        end
    end
endmodule

// File: rtl/disp_selftest.sv
module disp_selftest
    import st_pkg::*;
#(
    parameter int unsigned PHASE_W = 17,
    parameter int unsigned ROM_AW  = 7,
    parameter int unsigned CHAR_N  = 8,
    parameter int unsigned ROWS    = 7,
    parameter int unsigned COLS    = 5,
    parameter logic [15:0] EXP_SUM = rom_sum(1 << ROM_AW)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_wr,
    input  logic [7:0]                host_wdata,
    input  logic                      rom_fault,
    output logic [7:0]                ctrl_rdata,
    output logic                      busy,
    output logic [$clog2(ROWS)-1:0]   led_row,
    output logic [COLS-1:0]           led_cols,
    output logic                      mem_we,
    output logic [1:0]                mem_sel,
    output logic [$clog2(CHAR_N)-1:0] mem_addr,
    output logic [7:0]                mem_wdata
);
    localparam int unsigned CNT_W   = PHASE_W + 1;
    localparam int unsigned ROM_N   = 1 << ROM_AW;
    localparam int unsigned TOTAL   = 1 << CNT_W;
    localparam int unsigned ROW_W   = $clog2(ROWS);
    localparam int unsigned CHAR_AW = $clog2(CHAR_N);
    localparam int unsigned START_B = 6;
    localparam int unsigned RES_B   = 5;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [15:0]      sum;
        logic [ROW_W-1:0] row;
        logic [7:0]       ctrl;
    } st_state_t;

    st_state_t st_d, st_q;
    logic [7:0] rom_data;
    logic       pass;

    st_rom #(.ROM_AW(ROM_AW)) u_rom (
        .addr  (st_q.cnt[ROM_AW-1:0]),
        .fault (rom_fault),
        .data  (rom_data)
    );

    assign pass = (st_q.sum == EXP_SUM);

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (host_wr) begin
                st_d.ctrl = {host_wdata[7:6], st_q.ctrl[RES_B], host_wdata[4:0]};
                if (host_wdata[START_B]) begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                    st_d.sum  = '0;
                    st_d.row  = '0;
                end
            end
        end else begin
            if (st_q.cnt < CNT_W'(ROM_N)) begin
                st_d.sum = st_q.sum + 16'(rom_data);
            end
            st_d.row = (st_q.row == ROW_W'(ROWS - 1)) ? '0 : st_q.row + 1'b1;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(TOTAL - 1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
                st_d.row  = '0;
                st_d.ctrl = 8'(pass) << RES_B;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    st_pattern #(.ROW_W(ROW_W), .COLS(COLS)) u_pat (
        .en     (st_q.busy),
        .invert (st_q.cnt[CNT_W-1]),
        .row    (st_q.row),
        .cols   (led_cols)
    );

    st_init_seq #(.CNT_W(CNT_W), .CHAR_N(CHAR_N), .AW(CHAR_AW)) u_init (
        .en    (st_q.busy),
        .cnt   (st_q.cnt),
        .we    (mem_we),
        .sel   (mem_sel),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    assign ctrl_rdata = st_q.ctrl;
    assign busy       = st_q.busy;
    assign led_row    = st_q.row;
endmodule

// File: rtl/st_checker.sv
module st_checker #(
    parameter int unsigned TOTAL = 1024,
    parameter int unsigned COLS  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_wr,
    input logic            busy,
    input logic [7:0]      ctrl_rdata,
    input logic [COLS-1:0] led_cols,
    input logic            mem_we
);
    localparam logic [COLS-1:0] ALT_MASK = COLS'((1 << (COLS - 1)) - 1);

    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (busy) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    assert_test_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == TOTAL);

    assert_result_bit_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_wr) |=> ctrl_rdata[5] == $past(ctrl_rdata[5]));

    assert_ctrl_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy -> $stable(ctrl_rdata)));

    assert_checker_alternates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (((led_cols ^ (led_cols >> 1)) & ALT_MASK) == ALT_MASK));

    assert_cols_dark_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> led_cols == '0);

    assert_end_ctrl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (ctrl_rdata & 8'hDF) == 8'h00);

    assert_no_write_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
endmodule

bind disp_selftest st_checker #(
    .TOTAL (1 << (PHASE_W + 1)),
    .COLS  (COLS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .busy       (busy),
    .ctrl_rdata (ctrl_rdata),
    .led_cols   (led_cols),
    .mem_we     (mem_we)
);

// File: tb/tb_disp_selftest.sv
`timescale 1ns/1ps
module tb_disp_selftest;
    localparam int PHASE_W = 10;
    localparam int ROM_AW  = 6;
    localparam int CHAR_N  = 8;
    localparam int ROWS    = 7;
    localparam int COLS    = 5;
    localparam int TOTAL   = 1 << (PHASE_W + 1);
    localparam int HALF    = 1 << PHASE_W;
    localparam int INIT_N  = 2 * CHAR_N + 1;

    function automatic int ref_sum(input bit fault);
        int s = 0;
        for (int a = 0; a < (1 << ROM_AW); a++) begin
            int w = (29 * a + 7) % 256;
            if (a == 0 && fault) w = w ^ 1;
            s = (s + w) % 65536;
        end
        return s;
    endfunction

    localparam logic [15:0] EXP = 16'(ref_sum(1'b0));

    logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0, rom_fault = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] ctrl_rdata, mem_wdata;
    logic busy, mem_we;
    logic [$clog2(ROWS)-1:0] led_row;
    logic [COLS-1:0] led_cols;
    logic [1:0] mem_sel;
    logic [$clog2(CHAR_N)-1:0] mem_addr;

    always #5 clk = ~clk;

    disp_selftest #(
        .PHASE_W(PHASE_W), .ROM_AW(ROM_AW), .CHAR_N(CHAR_N),
        .ROWS(ROWS), .COLS(COLS), .EXP_SUM(EXP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .rom_fault(rom_fault), .ctrl_rdata(ctrl_rdata), .busy(busy),
        .led_row(led_row), .led_cols(led_cols), .mem_we(mem_we),
        .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int checks = 0, fails = 0;
    bit cmp_en = 0, done = 0;

    // reference model
    bit m_busy = 0;
    int m_t = 0;
    logic [7:0] m_ctrl = 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_ctrl = 8'h00;
        end else if (!m_busy) begin
            if (host_wr) begin
                m_ctrl = {host_wdata[7:6], m_ctrl[5], host_wdata[4:0]};
                if (host_wdata[6]) begin m_busy = 1; m_t = 0; end
            end
        end else begin
            m_t++;
            if (m_t == TOTAL) begin
                m_busy = 0; m_t = 0;
                m_ctrl = (ref_sum(rom_fault) == int'(EXP)) ? 8'h20 : 8'h00;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int row, k, e_we, e_sel, e_addr, e_dat;
        logic [COLS-1:0] e_cols;
        row = m_busy ? (m_t % ROWS) : 0;
        for (int c = 0; c < COLS; c++)
            e_cols[c] = m_busy ? (((row + c) % 2 == 1) ^ (m_t >= HALF)) : 1'b0;
        e_we = 0; e_sel = 0; e_addr = 0; e_dat = 0;
        if (m_busy && m_t >= TOTAL - INIT_N) begin
            k = m_t - (TOTAL - INIT_N);
            e_we = 1;
            if (k < CHAR_N) begin e_sel = 0; e_addr = k; e_dat = 8'h20; end
            else if (k < 2 * CHAR_N) begin e_sel = 1; e_addr = k - CHAR_N; e_dat = 0; end
            else begin e_sel = 2; e_dat = 8'hFF; end
        end
        check(busy == m_busy, "R2 busy", busy, m_busy);
        check(ctrl_rdata == m_ctrl, "R3/R4/R8 ctrl", ctrl_rdata, m_ctrl);
        check(int'(led_row) == row, "R6 row", led_row, row);
        check(led_cols == e_cols, "R6 cols", led_cols, e_cols);
        check(int'(mem_we) == e_we, "R7/R9 we", mem_we, e_we);
        if (e_we == 1) begin
            check(int'(mem_sel) == e_sel, "R7 sel", mem_sel, e_sel);
            check(int'(mem_addr) == e_addr, "R7 addr", mem_addr, e_addr);
            check(int'(mem_wdata) == e_dat, "R7 data", mem_wdata, e_dat);
        end
    endtask

    always @(negedge clk) if (cmp_en && !done) compare_all();

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); #1;
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic run_test(input logic [7:0] d, input bit fault, input logic [7:0] exp_end);
        rom_fault = fault;
        wr(d);
        repeat (100) @(negedge clk);
        #1; host_wr = 1'b1; host_wdata = 8'hE0;   // R4 ignored write with start bit
        @(negedge clk); #1; host_wr = 1'b0;
        repeat (TOTAL - 200) @(negedge clk);
        #1; host_wr = 1'b1; host_wdata = 8'h7F;   // R4 ignored write late in test
        @(negedge clk); #1; host_wr = 1'b0;
        while (busy) @(negedge clk);
        #1;
        check(ctrl_rdata == exp_end, "R5/R8 end result", ctrl_rdata, exp_end);
        rom_fault = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(ctrl_rdata == 8'h00 && busy == 1'b0 && mem_we == 1'b0 && led_cols == '0,
              "R1 reset", {ctrl_rdata, 3'b0, busy, 3'b0, mem_we}, 0);
        cmp_en = 1;
        @(negedge clk); #1; rst_n = 1'b1;
        repeat (3) @(negedge clk);
        wr(8'hBF);                               // R3 bit 5 must stay 0
        @(negedge clk); #1;
        check(ctrl_rdata == 8'h9F, "R3 idle write", ctrl_rdata, 8'h9F);
        run_test(8'h40, 1'b0, 8'h20);            // R5 clean ROM passes
        wr(8'h1F);                               // R3 bit 5 must stay 1
        @(negedge clk); #1;
        check(ctrl_rdata == 8'h3F, "R3 keep result", ctrl_rdata, 8'h3F);
        run_test(8'h40, 1'b1, 8'h00);            // R5 corrupted word fails
        wr(8'h20);
        @(negedge clk); #1;
        check(ctrl_rdata == 8'h00, "R3 bit5 not writable", ctrl_rdata, 8'h00);
        run_test(8'hC3, 1'b0, 8'h20);            // R5 pass after a failed run
        repeat (5) @(negedge clk);
        done = 1;
        summary();
    end

    initial begin
        #(10 * 20000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end
endmodule